// File: doc/BRIEF.md
# Daisy-Chain Poll Capture and Propagate Controller

This block is the device-side end of a polled, daisy-chained I/O channel. It keeps two kinds of pending request. An interrupt request is shown on one bit of a multi-bit request bus, and the bit is picked by a programmed level. A cycle-steal request is shown on a single line of its own. The channel answers requests by first raising poll identifier bits that name the request type being served. It then raises a poll tag that travels down the chain. Each device in the chain either keeps (captures) the poll or hands it on to the next device.

Configuration arrives as commands that are taken on the rising edge of a command strobe. A prepare command loads the interrupt level and the interrupt-enable (mask) bit. A device-reset command withdraws the interrupt request. A device reset does not cancel a pending cycle-steal request. Instead it marks that request so the transfer it produces is a dummy storage read, and the transfer logic ends any burst with it.

The capture-or-pass decision is made against the pending requests during a window of a configurable number of cycles after the poll identifier appears. After that window the decision is frozen until the identifier goes away. When the block captures a poll, it gives a one-cycle pulse that tells the transfer logic which request type won and whether the transfer is a dummy.

Top module: `poll_chain_dev`

## Requirements
- R1: While reset (`rst_n` low) is applied, and in the cycle after it, `req_bus`, `cs_req`, `poll_out`, `cap_pulse`, `cap_cs` and `cap_dummy` are all 0. The mask bit resets to 0.
- R2: An `irq_event` pulse while the mask bit is 1 makes exactly bit `level` of `req_bus` high from the next cycle on. An `irq_event` pulse while the mask bit is 0 is ignored, and `req_bus` stays 0.
- R3: A prepare command (a rising `cmd_stb` with `cmd_prep`=1) loads `prep_level` and `prep_imask`. A pending interrupt moves to the new level, or is dropped when the new mask is 0, in the cycle after the strobe edge, while `cmd_stb` is still high.
- R4: A device-reset command (a rising `cmd_stb` with `cmd_devrst`=1) drops the interrupt request and clears the mask bit. `halt_mchk` or `sys_reset` drops both the interrupt request and the cycle-steal request from the next cycle on.
- R5: `cs_event` raises `cs_req`. A device-reset command leaves a pending `cs_req` high and marks it as a dummy, so its capture reports `cap_dummy`=1.
- R6: On the first cycle of `poll_in` with a matching decision, `cap_pulse` is high for exactly one cycle, one cycle after the rise. The captured request is dropped in that same cycle, and `poll_out` stays 0 for the whole poll.
- R7: With no matching decision, `poll_out` goes high one cycle after `poll_in` rises. It goes low in the same cycle that `poll_in` goes low, and `cap_pulse` stays 0.
- R8: The decision is latched `DECIDE_CYC` cycles (default 3) after the poll identifier first appears. A request raised later does not cause a capture, and that request stays pending.
- R9: A request that becomes pending inside the decision window, after the identifier has appeared, is captured.
- R10: The latched decision is cleared when all poll identifier bits are 0, so the next poll sequence is decided again from the current requests.
- R11: When the identifier matches both a pending cycle-steal request (`poll_id_cs`) and the pending interrupt level (`poll_id_lvl[level]`), the cycle-steal request is captured (`cap_cs`=1). The interrupt request stays pending.
- R12: A `cs_event` while a dummy-marked request is pending keeps the dummy mark. After the dummy capture, the next normal cycle-steal capture reports `cap_dummy`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| halt_mchk | input | 1 | Halt / machine-check, clears all requests |
| sys_reset | input | 1 | System reset, clears all requests |
| irq_event | input | 1 | External interrupting condition (pulse) |
| cs_event | input | 1 | Storage access needed (pulse) |
| cmd_stb | input | 1 | Command data strobe, command taken on its rising edge |
| cmd_prep | input | 1 | Selects the prepare command |
| cmd_devrst | input | 1 | Selects the device-reset command |
| prep_level | input | LVL_W | Interrupt level for a prepare command |
| prep_imask | input | 1 | Mask bit for a prepare command |
| poll_id_lvl | input | 2**LVL_W | Poll identifier, one bit per interrupt level |
| poll_id_cs | input | 1 | Poll identifier for cycle steal |
| poll_in | input | 1 | Incoming poll tag |
| req_bus | output | 2**LVL_W | Interrupt request bus |
| cs_req | output | 1 | Cycle-steal request |
| poll_out | output | 1 | Poll tag passed to the next device |
| cap_pulse | output | 1 | One-cycle poll-captured pulse |
| cap_cs | output | 1 | With `cap_pulse`: 1 for cycle steal, 0 for interrupt |
| cap_dummy | output | 1 | With `cap_pulse`: the transfer is a dummy read |

## Verification
Poll sequences are run with several identifier patterns:
- An identifier for a different level than the pending one, which must pass the poll on.
- The matching level, which must capture.
- Both types at once, which separates the cycle-steal priority from the interrupt path.

The decision timing is tried with the request raised inside the window and with it raised after the window. Those two runs separate a live decision from a frozen one, and a follow-up sequence shows the frozen decision is cleared when the identifier drops.

Device reset is applied with and without a pending cycle steal. A scoreboard of expected captures then tells a dummy transfer apart from a normal one.

// File: rtl/poll_pkg.sv
// Shared types for the poll capture/propagate controller.
package poll_pkg;

    // Per-poll progress of the incoming poll tag at this device.
    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,   // no poll seen since it last dropped
        PS_PASS = 2'd1,   // poll forwarded to the next device
        PS_HELD = 2'd2    // poll captured here
    } poll_st_e;

endpackage

// File: rtl/pchn_irq_req.sv
// Interrupt request holder.
// Keeps the mask bit, the programmed level and the pending flag, and drives
// the one-hot request bus. Assumes the command inputs are single-cycle
// take pulses produced by the top module.
module pchn_irq_req #(
    parameter int LVL_W = 2,
    localparam int NLVL = 1 << LVL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hard_clr,
    input  logic             devrst_take,
    input  logic             prep_take,
    input  logic [LVL_W-1:0] prep_level,
    input  logic             prep_imask,
    input  logic             irq_event,
    input  logic             cap_clr,
    output logic [NLVL-1:0]  req_bus
);

    logic             pend_q;
    logic             mask_q;
    logic [LVL_W-1:0] level_q;

    // Pending/mask/level update: resets first, then commands, then capture, then new events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            mask_q  <= 1'b0;
            level_q <= '0;
        end else if (hard_clr || devrst_take) begin
            pend_q <= 1'b0;
            mask_q <= 1'b0;
        end else if (prep_take) begin
            mask_q  <= prep_imask;
            level_q <= prep_level;
            pend_q  <= pend_q && prep_imask;
        end else if (cap_clr) begin
            pend_q <= 1'b0;
        end else if (irq_event && mask_q) begin
            pend_q <= 1'b1;
        end
    end

    // One request bit per level, only the programmed one may be high.
    for (genvar g = 0; g < NLVL; g++) begin : g_lvl
        assign req_bus[g] = pend_q && (level_q == LVL_W'(g));
    end

endmodule

// File: rtl/pchn_cs_req.sv
// Cycle-steal request holder.
// A device reset does not withdraw a pending request; it marks it as a
// dummy read that must close any burst. Only capture or a hard clear
// drop the request.
module pchn_cs_req (
    input  logic clk,
    input  logic rst_n,
    input  logic hard_clr,
    input  logic devrst_take,
    input  logic cs_event,
    input  logic cap_clr,
    output logic cs_req,
    output logic cs_dummy
);

    logic pend_q;
    logic dummy_q;

    // Request and dummy-mark update.
    always_ff @(posedge clk) begin
        if (!rst_n || hard_clr) begin
            pend_q  <= 1'b0;
            dummy_q <= 1'b0;
        end else if (cap_clr) begin
            pend_q  <= 1'b0;
            dummy_q <= 1'b0;
        end else begin
            if (cs_event) begin
                pend_q <= 1'b1;
            end
            if (devrst_take && pend_q) begin
                dummy_q <= 1'b1;
            end
        end
    end

    assign cs_req   = pend_q;
    assign cs_dummy = dummy_q;

endmodule

// File: rtl/pchn_poll_dec.sv
// Capture/propagate decision and poll handling.
// While any identifier bit is high, a counter times the decision window.
// At DECIDE_CYC cycles, or at the poll leading edge if sooner, the live
// match is latched and held until the identifier drops. On the poll
// leading edge the poll is captured or passed on. Assumes poll_in is
// synchronous to clk.
module pchn_poll_dec
    import poll_pkg::*;
#(
    parameter int NLVL       = 4,
    parameter int DECIDE_CYC = 3,
    localparam int CNT_W     = $clog2(DECIDE_CYC + 1) + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NLVL-1:0] id_lvl,
    input  logic            id_cs,
    input  logic            poll_in,
    input  logic [NLVL-1:0] irq_req,
    input  logic            cs_req,
    input  logic            cs_dummy,
    output logic            cap_fire,
    output logic            cap_fire_cs,
    output logic            poll_out,
    output logic            cap_pulse,
    output logic            cap_cs,
    output logic            cap_dummy
);

    localparam logic [CNT_W-1:0] WIN_END = CNT_W'(DECIDE_CYC);

    logic [CNT_W-1:0] cnt_q;
    logic             dec_valid_q;
    logic             dec_cap_q;
    logic             dec_cs_q;
    poll_st_e         st_q;

    logic id_any;
    logic live_cs;
    logic live_cap;
    logic poll_rise;
    logic take_now;
    logic eff_cap;
    logic eff_cs;

    // Live match and effective (latched or live) decision.
    always_comb begin
        id_any    = id_cs || (|id_lvl);
        live_cs   = id_cs && cs_req;
        live_cap  = live_cs || (|(id_lvl & irq_req));
        poll_rise = poll_in && (st_q == PS_IDLE);
        take_now  = id_any && !dec_valid_q && ((cnt_q == WIN_END) || poll_rise);
        eff_cap   = dec_valid_q ? dec_cap_q : live_cap;
        eff_cs    = dec_valid_q ? dec_cs_q  : live_cs;
    end

    // Window counter and decision latch, cleared when the identifier drops.
    always_ff @(posedge clk) begin
        if (!rst_n || !id_any) begin
            cnt_q       <= '0;
            dec_valid_q <= 1'b0;
            dec_cap_q   <= 1'b0;
            dec_cs_q    <= 1'b0;
        end else begin
            if (cnt_q != WIN_END) begin
                cnt_q <= cnt_q + 1'b1;
            end
            if (take_now) begin
                dec_valid_q <= 1'b1;
                dec_cap_q   <= live_cap;
                dec_cs_q    <= live_cs;
            end
        end
    end

    // Poll tag state: capture or pass on the leading edge, idle once it drops.
    always_ff @(posedge clk) begin
        if (!rst_n || !poll_in) begin
            st_q <= PS_IDLE;
        end else if (poll_rise) begin
            st_q <= eff_cap ? PS_HELD : PS_PASS;
        end
    end

    // Capture report pulse for the transfer logic.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_pulse <= 1'b0;
            cap_cs    <= 1'b0;
            cap_dummy <= 1'b0;
        end else begin
            cap_pulse <= cap_fire;
            cap_cs    <= cap_fire && eff_cs;
            cap_dummy <= cap_fire && eff_cs && cs_dummy;
        end
    end

    assign cap_fire    = poll_rise && eff_cap;
    assign cap_fire_cs = eff_cs;
    assign poll_out    = poll_in && (st_q == PS_PASS);

endmodule

// File: rtl/poll_chain_dev.sv
// Top of the daisy-chain poll controller.
// Detects command strobe edges, and wires the interrupt holder, the
// cycle-steal holder and the decision logic together. Assumes cmd_stb
// stays high for at least two cycles per command.
module poll_chain_dev #(
    parameter int LVL_W      = 2,
    parameter int DECIDE_CYC = 3,
    localparam int NLVL      = 1 << LVL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             halt_mchk,
    input  logic             sys_reset,
    input  logic             irq_event,
    input  logic             cs_event,
    input  logic             cmd_stb,
    input  logic             cmd_prep,
    input  logic             cmd_devrst,
    input  logic [LVL_W-1:0] prep_level,
    input  logic             prep_imask,
    input  logic [NLVL-1:0]  poll_id_lvl,
    input  logic             poll_id_cs,
    input  logic             poll_in,
    output logic [NLVL-1:0]  req_bus,
    output logic             cs_req,
    output logic             poll_out,
    output logic             cap_pulse,
    output logic             cap_cs,
    output logic             cap_dummy
);

    logic stb_q;
    logic stb_rise;
    logic prep_take;
    logic devrst_take;
    logic hard_clr;
    logic cap_fire;
    logic cap_fire_cs;
    logic cs_dummy;

    // Strobe history for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stb_q <= 1'b0;
        end else begin
            stb_q <= cmd_stb;
        end
    end

    assign stb_rise    = cmd_stb && !stb_q;
    assign prep_take   = stb_rise && cmd_prep;
    assign devrst_take = stb_rise && cmd_devrst;
    assign hard_clr    = halt_mchk || sys_reset;

    pchn_irq_req #(.LVL_W(LVL_W)) u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .hard_clr    (hard_clr),
        .devrst_take (devrst_take),
        .prep_take   (prep_take),
        .prep_level  (prep_level),
        .prep_imask  (prep_imask),
        .irq_event   (irq_event),
        .cap_clr     (cap_fire && !cap_fire_cs),
        .req_bus     (req_bus)
    );

    pchn_cs_req u_cs (
        .clk         (clk),
        .rst_n       (rst_n),
        .hard_clr    (hard_clr),
        .devrst_take (devrst_take),
        .cs_event    (cs_event),
        .cap_clr     (cap_fire && cap_fire_cs),
        .cs_req      (cs_req),
        .cs_dummy    (cs_dummy)
    );

    pchn_poll_dec #(.NLVL(NLVL), .DECIDE_CYC(DECIDE_CYC)) u_dec (
        .clk         (clk),
        .rst_n       (rst_n),
        .id_lvl      (poll_id_lvl),
        .id_cs       (poll_id_cs),
        .poll_in     (poll_in),
        .irq_req     (req_bus),
        .cs_req      (cs_req),
        .cs_dummy    (cs_dummy),
        .cap_fire    (cap_fire),
        .cap_fire_cs (cap_fire_cs),
        .poll_out    (poll_out),
        .cap_pulse   (cap_pulse),
        .cap_cs      (cap_cs),
        .cap_dummy   (cap_dummy)
    );

endmodule

// File: rtl/poll_chain_dev_chk.sv
// Property checker for poll_chain_dev, attached by bind.
module poll_chain_dev_chk #(
    parameter int NLVL = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            halt_mchk,
    input logic            sys_reset,
    input logic            cmd_stb,
    input logic            cmd_prep,
    input logic            cmd_devrst,
    input logic            prep_imask,
    input logic            poll_in,
    input logic [NLVL-1:0] req_bus,
    input logic            cs_req,
    input logic            poll_out,
    input logic            cap_pulse,
    input logic            cap_cs
);

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (req_bus == '0 && !cs_req && !cap_pulse && !poll_out)); // R1

    AST_REQ_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_bus)); // R2

    AST_MASKOFF_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cmd_stb) && cmd_prep && !prep_imask) |=> (req_bus == '0)); // R3

    AST_HARD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_mchk || sys_reset) |=> (req_bus == '0 && !cs_req)); // R4

    AST_DEVRST_KEEPS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cmd_stb) && cmd_devrst && cs_req && !halt_mchk && !sys_reset)
        |=> (cs_req || (cap_pulse && cap_cs))); // R5

    AST_CAP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cap_pulse |=> !cap_pulse); // R6

    AST_CAP_NOT_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        !(cap_pulse && poll_out)); // R6

    AST_CAP_DROPS_CS: assert property (@(posedge clk) disable iff (!rst_n)
        (cap_pulse && cap_cs) |-> !cs_req); // R6

    AST_POLL_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        !poll_in |-> !poll_out); // R7

endmodule

bind poll_chain_dev poll_chain_dev_chk #(.NLVL(NLVL)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .halt_mchk  (halt_mchk),
    .sys_reset  (sys_reset),
    .cmd_stb    (cmd_stb),
    .cmd_prep   (cmd_prep),
    .cmd_devrst (cmd_devrst),
    .prep_imask (prep_imask),
    .poll_in    (poll_in),
    .req_bus    (req_bus),
    .cs_req     (cs_req),
    .poll_out   (poll_out),
    .cap_pulse  (cap_pulse),
    .cap_cs     (cap_cs)
);

// File: tb/test_poll_chain_dev.sv
// Scoreboard bench: poll tasks push the expected capture reports,
// a negedge monitor pops and compares them when cap_pulse appears.
module test_poll_chain_dev;

    localparam int LVL_W = 2;
    localparam int NLVL  = 1 << LVL_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             halt_mchk = 1'b0;
    logic             sys_reset = 1'b0;
    logic             irq_event = 1'b0;
    logic             cs_event = 1'b0;
    logic             cmd_stb = 1'b0;
    logic             cmd_prep = 1'b0;
    logic             cmd_devrst = 1'b0;
    logic [LVL_W-1:0] prep_level = '0;
    logic             prep_imask = 1'b0;
    logic [NLVL-1:0]  poll_id_lvl = '0;
    logic             poll_id_cs = 1'b0;
    logic             poll_in = 1'b0;
    logic [NLVL-1:0]  req_bus;
    logic             cs_req;
    logic             poll_out;
    logic             cap_pulse;
    logic             cap_cs;
    logic             cap_dummy;

    int n_tests = 0;
    int n_fail  = 0;
    logic [1:0] exp_q[$];   // {cs, dummy}
    bit done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    poll_chain_dev #(.LVL_W(LVL_W), .DECIDE_CYC(3)) i_poll_chain_dev (
        .clk(clk), .rst_n(rst_n), .halt_mchk(halt_mchk), .sys_reset(sys_reset),
        .irq_event(irq_event), .cs_event(cs_event), .cmd_stb(cmd_stb),
        .cmd_prep(cmd_prep), .cmd_devrst(cmd_devrst), .prep_level(prep_level),
        .prep_imask(prep_imask), .poll_id_lvl(poll_id_lvl), .poll_id_cs(poll_id_cs),
        .poll_in(poll_in), .req_bus(req_bus), .cs_req(cs_req), .poll_out(poll_out),
        .cap_pulse(cap_pulse), .cap_cs(cap_cs), .cap_dummy(cap_dummy)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Monitor: compare every capture report against the scoreboard.
    always @(negedge clk) begin
        if (rst_n && cap_pulse) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R7 unexpected capture", 1, 0);
            end else begin
                logic [1:0] e;
                e = exp_q.pop_front();
                chk({cap_cs, cap_dummy} == e, "R6 capture report", int'({cap_cs, cap_dummy}), int'(e));
            end
        end
    end

    task automatic pulse_irq();
        tick(); irq_event = 1'b1; tick(); irq_event = 1'b0;
    endtask

    task automatic pulse_cs();
        tick(); cs_event = 1'b1; tick(); cs_event = 1'b0;
    endtask

    // Start a command; returns at the negedge after it is taken, strobe still high.
    task automatic cmd_begin(input bit prep, input bit devrst, input int lvl, input bit msk);
        tick();
        cmd_stb = 1'b1; cmd_prep = prep; cmd_devrst = devrst;
        prep_level = LVL_W'(lvl); prep_imask = msk;
        tick();
        @(negedge clk);
    endtask

    task automatic cmd_end();
        tick();
        cmd_stb = 1'b0; cmd_prep = 1'b0; cmd_devrst = 1'b0;
    endtask

    // Poll with identifier raised before the window; pass or capture expected.
    task automatic poll_seq(input logic [NLVL-1:0] idl, input bit idc,
                            input bit exp_pass, input bit ecs, input bit edum, input string req);
        if (!exp_pass) exp_q.push_back({ecs, edum});
        tick();
        poll_id_lvl = idl; poll_id_cs = idc;
        repeat (5) tick();
        poll_in = 1'b1;
        tick();
        @(negedge clk);
        chk(poll_out == exp_pass, req, int'(poll_out), int'(exp_pass));
        tick();
        poll_in = 1'b0;
        @(negedge clk);
        chk(poll_out == 1'b0, "R7 poll_out follows drop", int'(poll_out), 0);
        tick();
        poll_id_lvl = '0; poll_id_cs = 1'b0;
        tick();
    endtask

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++; n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        @(negedge clk);
        chk(req_bus == '0 && !cs_req && !poll_out && !cap_pulse, "R1 reset quiet",
            int'(req_bus), 0);
        tick(); rst_n = 1'b1;
        @(negedge clk);
        chk(req_bus == '0 && !cs_req, "R1 after reset", int'(req_bus), 0);

        // R2: mask off ignores the event
        pulse_irq(); @(negedge clk);
        chk(req_bus == '0, "R2 masked event ignored", int'(req_bus), 0);
        cmd_begin(1, 0, 2, 1); cmd_end();
        pulse_irq(); @(negedge clk);
        chk(req_bus == 4'b0100, "R2 level 2 request", int'(req_bus), 4);

        // R3: move level while strobe high
        cmd_begin(1, 0, 1, 1);
        chk(req_bus == 4'b0010 && cmd_stb, "R3 level move", int'(req_bus), 2);
        cmd_end();

        // R7: wrong level passes on
        poll_seq(4'b0100, 0, 1, 0, 0, "R7 pass on mismatch");
        chk(req_bus == 4'b0010, "R7 request kept", int'(req_bus), 2);

        // R6: matching level captures
        poll_seq(4'b0010, 0, 0, 0, 0, "R6 capture no pass");
        chk(req_bus == '0, "R6 request dropped", int'(req_bus), 0);

        // R8: request after the window does not capture
        tick(); poll_id_lvl = 4'b0010;
        repeat (5) tick();
        irq_event = 1'b1; tick(); irq_event = 1'b0;
        tick(); poll_in = 1'b1; tick();
        @(negedge clk);
        chk(poll_out == 1'b1, "R8 frozen decision passes", int'(poll_out), 1);
        tick(); poll_in = 1'b0; tick(); poll_id_lvl = '0; tick();
        @(negedge clk);
        chk(req_bus == 4'b0010, "R8 late request kept", int'(req_bus), 2);

        // R10: next sequence decides afresh
        poll_seq(4'b0010, 0, 0, 0, 0, "R10 re-decided capture");

        // R9: request inside the window is captured
        exp_q.push_back(2'b00);
        tick(); poll_id_lvl = 4'b0010;
        tick(); irq_event = 1'b1; tick(); irq_event = 1'b0;
        repeat (4) tick();
        poll_in = 1'b1; tick();
        @(negedge clk);
        chk(poll_out == 1'b0, "R9 in-window capture", int'(poll_out), 0);
        tick(); poll_in = 1'b0; tick(); poll_id_lvl = '0; tick();

        // R3: prepare with mask 0 drops the request
        pulse_irq();
        cmd_begin(1, 0, 1, 0);
        chk(req_bus == '0 && cmd_stb, "R3 mask clear drop", int'(req_bus), 0);
        cmd_end();

        // R4: device reset drops the interrupt and clears the mask
        cmd_begin(1, 0, 1, 1); cmd_end();
        pulse_irq();
        cmd_begin(0, 1, 0, 0);
        chk(req_bus == '0, "R4 devrst drops irq", int'(req_bus), 0);
        cmd_end();
        pulse_irq(); @(negedge clk);
        chk(req_bus == '0, "R4 mask cleared by devrst", int'(req_bus), 0);

        // R5: device reset keeps cycle steal, capture is dummy
        pulse_cs(); @(negedge clk);
        chk(cs_req == 1'b1, "R5 cs raised", int'(cs_req), 1);
        cmd_begin(0, 1, 0, 0);
        chk(cs_req == 1'b1, "R5 cs kept on devrst", int'(cs_req), 1);
        cmd_end();
        poll_seq('0, 1, 0, 1, 1, "R5 dummy capture");
        chk(cs_req == 1'b0, "R5 cs dropped after capture", int'(cs_req), 0);

        // R12: dummy mark survives new event, then cleared
        pulse_cs();
        cmd_begin(0, 1, 0, 0); cmd_end();
        pulse_cs();
        poll_seq('0, 1, 0, 1, 1, "R12 dummy kept");
        pulse_cs();
        poll_seq('0, 1, 0, 1, 0, "R12 normal after dummy");

        // R11: cycle steal wins when both match
        cmd_begin(1, 0, 0, 1); cmd_end();
        pulse_irq(); pulse_cs();
        poll_seq(4'b0001, 1, 0, 1, 0, "R11 cs priority");
        chk(req_bus == 4'b0001, "R11 irq kept", int'(req_bus), 1);
        poll_seq(4'b0001, 0, 0, 0, 0, "R11 irq next");

        // R4: halt and system reset clear both requests
        pulse_irq(); pulse_cs();
        tick(); halt_mchk = 1'b1; tick(); halt_mchk = 1'b0;
        @(negedge clk);
        chk(req_bus == '0 && !cs_req, "R4 halt clears", int'({req_bus, cs_req}), 0);
        pulse_cs();
        tick(); sys_reset = 1'b1; tick(); sys_reset = 1'b0;
        @(negedge clk);
        chk(!cs_req, "R4 sys reset clears", int'(cs_req), 0);

        repeat (3) tick();
        chk(exp_q.size() == 0, "R6 all captures seen", exp_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule